// File: doc/BRIEF.md
# Clock Mode Controller with PLL Lock Timer

This block is the digital side of a programmable clock generator. It holds one 16-bit configuration register on a small register bus. During reset the register loads a value chosen by three strap inputs. The register fields select between two modes. In multiply mode an external PLL produces the master clock. In divide mode the master clock is the input clock halved or quartered, and the PLL can be powered down completely.

Entering multiply mode starts a lock countdown. The countdown is loaded from a register field and runs on the input clock. The master clock stays on the divided source until the countdown reaches zero. A glitch-free two-clock multiplexer then hands the output over to the PLL clock. A status bit in the register reads 1 once the PLL clock drives the output. Every write to the register first sends the output back to the divided source.

Top module: `clkmode_ctrl`

## Requirements
- R1: The register answers only at bus address 0x0058. A read at any other address returns 0, and a write to any other address changes nothing. Bit 0 reads the status; written values of bit 0 are ignored.
- R2: During reset the register loads a value from strap[2:0]: 000 gives 0xE007, 001 gives 0x9007, 010 gives 0x4007, 100 gives 0x1007, 110 gives 0xF007, 111 gives 0x0000 and 101 gives 0xF000. Bit 0 is compared as status, so only bits 15..1 are checked against these values.
- R3: The reserved strap pattern 011 loads 0x0000 (divide by 2) and drives strap_err to 1. Every other pattern leaves strap_err at 0.
- R4: The register fields are as follows. Bits 15..12 hold the multiplier code, bit 11 is an extra multiplier bit, bits 10..3 hold the lock count, bit 2 keeps the PLL powered, and bit 1 selects multiply mode when it is 1. pll_mult equals {bit 11, bits 15..12}.
- R5: pll_en is high when bit 1 or bit 2 is set. It also stays high while the PLL clock still drives the output. In divide mode with bit 2 clear, once the output has left the PLL, pll_en is 0.
- R6: In divide mode, mclk is clk_in divided by 4 when bits 15..12 equal 0xF, and clk_in divided by 2 otherwise.
- R7: After a write that sets bit 1 with lock count N, status stays 0 for at least N+1 clk_in cycles. It reads 1 within N+12 cycles, and mclk then runs from pll_clk.
- R8: Any register write drops the switch request the cycle after the write. If the block was in multiply mode, status returns to 0 and mclk runs from the divided clock again.
- R9: The two clock enables of the output multiplexer are never high at the same time.
- R10: After a reset with a multiply-mode strap, the lock count is 0 and status reads 1 within 12 cycles of reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input reference clock; clocks the register and the lock timer |
| rst_n | input | 1 | Active-low reset; the straps are sampled while it is low |
| strap | input | 3 | Strap pins that select the register reset value |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| pll_clk | input | 1 | Clock from the PLL |
| pll_en | output | 1 | PLL power enable |
| pll_mult | output | 5 | Multiplier code sent to the PLL |
| strap_err | output | 1 | Reserved strap pattern seen at reset |
| mclk | output | 1 | Selected master clock |

## Verification
Register reads are combinational, so the bench samples read data in the same cycle as the read, away from the clock edge. A write takes effect at the next rising edge of clk_in, and pll_en and pll_mult follow within that same edge. The earliest time status can rise is N+1 edges after the write edge, and it is certain to be up within N+12 edges, since the handover must pass through the divided-clock and PLL-clock synchronizers. The bench therefore samples status once at N+1 (expecting 0) and once at N+12 (expecting 1). Divide ratios are measured by counting mclk rising edges over a fixed window of clk_in cycles, with a tolerance of one edge.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   localparam int CFG_W = 16;
   localparam int LOCK_FIELD_W = 8;

   // Returns {reserved_flag, reset_value} for a strap pattern
   function automatic logic [CFG_W:0] strap_decode(input logic [2:0] s);
      logic [CFG_W:0] r;
      case (s)
         3'b000:  r = {1'b0, 16'hE007};
         3'b001:  r = {1'b0, 16'h9007};
         3'b010:  r = {1'b0, 16'h4007};
         3'b100:  r = {1'b0, 16'h1007};
         3'b110:  r = {1'b0, 16'hF007};
         3'b111:  r = {1'b0, 16'h0000};
         3'b101:  r = {1'b0, 16'hF000};
         default: r = {1'b1, 16'h0000};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/clkmode_lock_timer.sv
module clkmode_lock_timer #(
   parameter int LOCK_W     = 8,
   parameter int LOCK_SHIFT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LOCK_W-1:0] load_val,
   input  logic              mode,
   output logic              req,
   output logic              cnt_zero
);
   localparam int CW = LOCK_W + LOCK_SHIFT;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] ld_val;

   generate
      if (LOCK_SHIFT == 0) begin : g_noscale
         assign ld_val = load_val;
      end else begin : g_scale
         assign ld_val = {load_val, {LOCK_SHIFT{1'b0}}};
      end
   endgenerate

   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         req   <= 1'b0;
      end else begin
         if (load)
            cnt_q <= ld_val;
         else if (!cnt_zero)
            cnt_q <= cnt_q - 1'b1;
         req <= mode & ~load & cnt_zero;
      end
   end
endmodule

// File: rtl/clkmode_divider.sv
module clkmode_divider (
   input  logic clk,
   input  logic rst_n,
   input  logic div4,
   output logic div_clk
);
   logic [1:0] cnt_q;
   logic       div4_q;

   // ratio may change only at the wrap, where both taps are low next
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= 2'd0;
         div4_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 2'd1;
         if (cnt_q == 2'd3)
            div4_q <= div4;
      end
   end

   assign div_clk = div4_q ? cnt_q[1] : cnt_q[0];
endmodule

// File: rtl/clkmode_gmux.sv
module clkmode_gmux (
   input  logic rst_n,
   input  logic sel,
   input  logic clk_a,
   input  logic clk_b,
   output logic clk_out,
   output logic a_en,
   output logic b_en
);
   logic a_s1, b_s1;

   always_ff @(posedge clk_a or negedge rst_n)
      if (!rst_n) a_s1 <= 1'b0;
      else        a_s1 <= ~sel & ~b_en & ~b_s1;

   always_ff @(negedge clk_a or negedge rst_n)
      if (!rst_n) a_en <= 1'b0;
      else        a_en <= a_s1;

   always_ff @(posedge clk_b or negedge rst_n)
      if (!rst_n) b_s1 <= 1'b0;
      else        b_s1 <= sel & ~a_en & ~a_s1;

   always_ff @(negedge clk_b or negedge rst_n)
      if (!rst_n) b_en <= 1'b0;
      else        b_en <= b_s1;

   assign clk_out = (clk_a & a_en) | (clk_b & b_en);
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
   import clkmode_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int REG_ADDR   = 'h58,
   parameter int LOCK_SHIFT = 0
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic [2:0]        strap,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [15:0]       bus_wdata,
   output logic [15:0]       bus_rdata,
   input  logic              pll_clk,
   output logic              pll_en,
   output logic [4:0]        pll_mult,
   output logic              strap_err,
   output logic              mclk
);
   generate
      if (ADDR_W < 7 || ADDR_W > 32) begin : g_bad_addr_w
         $error("clkmode_ctrl: ADDR_W out of range");
      end
      if (LOCK_SHIFT < 0 || LOCK_SHIFT > 16) begin : g_bad_shift
         $error("clkmode_ctrl: LOCK_SHIFT out of range");
      end
   endgenerate

   logic [CFG_W-1:1] cfg_q;
   logic             err_q;
   logic [CFG_W:0]   strap_val;
   logic             hit, wr;
   logic             lock_req, lock_zero;
   logic             div_clk, mux_a_en, mux_b_en;
   logic [1:0]       st_q;
   logic             unused_bit0;

   assign strap_val   = strap_decode(strap);
   assign hit         = bus_sel && (bus_addr == ADDR_W'(REG_ADDR));
   assign wr          = hit && bus_we;
   assign unused_bit0 = bus_wdata[0] ^ strap_val[0];

   always_ff @(posedge clk_in) begin
      if (!rst_n) begin
         cfg_q <= strap_val[CFG_W-1:1];
         err_q <= strap_val[CFG_W];
      end else if (wr) begin
         cfg_q <= bus_wdata[CFG_W-1:1];
      end
   end

   clkmode_lock_timer #(
      .LOCK_W    (LOCK_FIELD_W),
      .LOCK_SHIFT(LOCK_SHIFT)
   ) u_timer (
      .clk     (clk_in),
      .rst_n   (rst_n),
      .load    (wr),
      .load_val(bus_wdata[10:3]),
      .mode    (cfg_q[1]),
      .req     (lock_req),
      .cnt_zero(lock_zero)
   );

   clkmode_divider u_div (
      .clk    (clk_in),
      .rst_n  (rst_n),
      .div4   (cfg_q[15:12] == 4'hF),
      .div_clk(div_clk)
   );

   clkmode_gmux u_mux (
      .rst_n  (rst_n),
      .sel    (lock_req),
      .clk_a  (div_clk),
      .clk_b  (pll_clk),
      .clk_out(mclk),
      .a_en   (mux_a_en),
      .b_en   (mux_b_en)
   );

   always_ff @(posedge clk_in or negedge rst_n)
      if (!rst_n) st_q <= 2'b00;
      else        st_q <= {st_q[0], mux_b_en};

   assign bus_rdata = hit ? {cfg_q, st_q[1]} : 16'h0000;
   assign pll_en    = cfg_q[2] | cfg_q[1] | mux_b_en;
   assign pll_mult  = {cfg_q[11], cfg_q[15:12]};
   assign strap_err = err_q;
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
   input logic clk_in,
   input logic rst_n,
   input logic wr,
   input logic req,
   input logic cnt_zero,
   input logic mode,
   input logic a_en,
   input logic b_en
);
   // R9
   mux_excl_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      !(a_en && b_en));

   // R7
   req_after_zero_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      $rose(req) |-> (cnt_zero && $past(cnt_zero)));

   // R8
   write_drops_req_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      wr |=> !req);

   // R7
   req_needs_mode_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
      req |-> mode);
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
   .clk_in  (clk_in),
   .rst_n   (rst_n),
   .wr      (wr),
   .req     (lock_req),
   .cnt_zero(lock_zero),
   .mode    (cfg_q[1]),
   .a_en    (mux_a_en),
   .b_en    (mux_b_en)
);

// File: tb/clkmode_ctrl_bench.sv
`timescale 1ns/1ps
module clkmode_ctrl_bench;
   logic        clk_in = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  strap = 3'b111;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [15:0] bus_addr = '0, bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pll_clk = 1'b0;
   logic        pll_en, strap_err, mclk;
   logic [4:0]  pll_mult;

   int checks = 0, errors = 0;
   int edges = 0;
   logic [15:0] rd;

   always #10 clk_in = ~clk_in;

   // behavioural PLL: fast clock while powered
   always begin
      if (pll_en) #3 pll_clk = ~pll_clk;
      else begin pll_clk = 1'b0; @(posedge pll_en); end
   end

   always @(posedge mclk) edges++;

   clkmode_ctrl u_clkmode_ctrl (
      .clk_in(clk_in), .rst_n(rst_n), .strap(strap),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_clk(pll_clk),
      .pll_en(pll_en), .pll_mult(pll_mult), .strap_err(strap_err), .mclk(mclk)
   );

   // {strap, value, strap_err, pll_en}
   localparam logic [20:0] VEC [8] = '{
      {3'b000, 16'hE007, 1'b0, 1'b1}, {3'b001, 16'h9007, 1'b0, 1'b1},
      {3'b010, 16'h4007, 1'b0, 1'b1}, {3'b100, 16'h1007, 1'b0, 1'b1},
      {3'b110, 16'hF007, 1'b0, 1'b1}, {3'b111, 16'h0000, 1'b0, 1'b0},
      {3'b101, 16'hF000, 1'b0, 1'b0}, {3'b011, 16'h0000, 1'b1, 1'b0}
   };

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] s);
      @(negedge clk_in);
      rst_n = 1'b0; strap = s;
      repeat (3) @(posedge clk_in);
      @(negedge clk_in);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk_in);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk_in);
      #1;
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic count_edges(input int cyc, output int n);
      @(negedge clk_in);
      edges = 0;
      repeat (cyc) @(negedge clk_in);
      n = edges;
   endtask

   task automatic lock_test(input int n);
      int e;
      bus_write(16'h0058, 16'h0000);
      repeat (20) @(posedge clk_in);
      bus_write(16'h0058, 16'h4006 | 16'(n << 3));
      check(pll_en === 1'b1, "R5 pll_en on multiply write", int'(pll_en), 1);
      repeat (n + 1) @(posedge clk_in);
      #5 bus_read(16'h0058, rd);
      check(rd[0] === 1'b0, "R7 status held during lock count", int'(rd[0]), 0);
      repeat (11) @(posedge clk_in);
      #5 bus_read(16'h0058, rd);
      check(rd[0] === 1'b1, "R7 status after lock count", int'(rd[0]), 1);
      count_edges(10, e);
      check(e > 25, "R7 mclk from pll_clk", e, 26);
   endtask

   initial begin
      #(20ns * 150000);
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int e;
      // R2 R3 R5: walk the strap table
      for (int i = 0; i < 8; i++) begin
         do_reset(VEC[i][20:18]);
         bus_read(16'h0058, rd);
         check((rd & 16'hFFFE) === (VEC[i][17:2] & 16'hFFFE), "R2 strap reset value",
               int'(rd & 16'hFFFE), int'(VEC[i][17:2] & 16'hFFFE));
         check(strap_err === VEC[i][1], "R3 strap_err", int'(strap_err), int'(VEC[i][1]));
         check(pll_en === VEC[i][0], "R5 pll_en after reset", int'(pll_en), int'(VEC[i][0]));
      end

      // R10: multiply strap switches right after reset
      do_reset(3'b000);
      repeat (12) @(posedge clk_in);
      #5 bus_read(16'h0058, rd);
      check(rd[0] === 1'b1, "R10 status after reset", int'(rd[0]), 1);

      // R7: lock delays
      lock_test(0);
      lock_test(5);
      lock_test(20);

      // R8: rewrite while on PLL returns to divided clock
      bus_write(16'h0058, 16'h40F6);
      repeat (12) @(posedge clk_in);
      #5 bus_read(16'h0058, rd);
      check(rd[0] === 1'b0, "R8 status drops on rewrite", int'(rd[0]), 0);

      // R6 R5: divide by 4, PLL off
      bus_write(16'h0058, 16'hF000);
      repeat (20) @(posedge clk_in);
      #5 check(pll_en === 1'b0, "R5 pll_en in divide-by-4", int'(pll_en), 0);
      count_edges(40, e);
      check(e >= 9 && e <= 11, "R6 divide by 4", e, 10);

      // R6 R5: divide by 2, PLL off
      bus_write(16'h0058, 16'h0000);
      repeat (10) @(posedge clk_in);
      #5 check(pll_en === 1'b0, "R5 pll_en in divide-by-2", int'(pll_en), 0);
      count_edges(40, e);
      check(e >= 19 && e <= 21, "R6 divide by 2", e, 20);

      // R1: bit 0 write ignored
      bus_write(16'h0058, 16'h0001);
      #5 bus_read(16'h0058, rd);
      check(rd === 16'h0000, "R1 bit0 write ignored", int'(rd), 0);

      // R1: other address
      bus_write(16'h0057, 16'hFFFF);
      #5 bus_read(16'h0058, rd);
      check(rd === 16'h0000, "R1 foreign write ignored", int'(rd), 0);
      bus_read(16'h0059, rd);
      check(rd === 16'h0000, "R1 foreign read zero", int'(rd), 0);

      // R4: multiplier code
      bus_write(16'h0058, 16'h9806);
      #5 check(pll_mult === 5'b11001, "R4 pll_mult", int'(pll_mult), 'h19);
      bus_read(16'h0058, rd);
      check((rd & 16'hFFFE) === 16'h9806, "R4 readback", int'(rd & 16'hFFFE), 'h9806);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule